// File: doc/BRIEF.md
# Receive Character Error and Status Accumulator

This block sits between a serial character receiver and a DMA byte writer. For every character the receiver delivers during an active receive operation, it decides what byte goes to memory. It issues a one-cycle store strobe and counts the remaining byte count down. It also gathers the error conditions of the operation into a 16-bit status word and an 8-bit interrupt status byte.

A character with bad parity is normally replaced by zero before it is stored. A mode input keeps the character as received instead. A parity error, or an overrun seen while the DMA writer was still busy, only marks the operation as failed. The exception request for it waits until the message ends, either on an end-of-message (COD) character or when the count runs out with chaining off. A missing stop bit requests the exception at once and ends the operation. Ending on the count without a COD, or on a COD before the count is used up, reports an incorrect-length condition.

A receive operation begins with a start pulse that loads the byte count and clears all accumulated status. A status read pulse also clears the accumulated status. Every output comes from a register, so it is valid one clock after the inputs that caused it.

Top module: `rx_char_status_acc`

## Requirements
- R1: A character is accepted when chr_vld_i is high while an operation is active and start_i is low. One cycle after acceptance, st_wr_o is high for one cycle. If the character had no parity error, st_data_o equals the received byte.
- R2: For an accepted character with chr_perr_i high, st_data_o is 0x00 when zero_inh_i is 0. When zero_inh_i is 1, st_data_o is the byte exactly as received.
- R3: An accepted parity-error character sets status_o[5]. It causes no exception in that cycle. The exception comes on the accepted character that ends the message, which is a COD character or the last counted byte with chain_i low.
- R4: An accepted character with chr_stoperr_i high sets status_o[7], raises exc_o in the next cycle and ends the operation.
- R5: An accepted character that arrives while dma_busy_i is high sets status_o[0] (overrun). The overrun is reported at message end in the same way as a parity error. Error bits accumulate, so bits 0, 5 and 7 may be set together.
- R6: When the last counted byte is accepted without a COD and with chain_i low, isb_o[2] becomes 1, isb_o[0] stays 0 and exc_o is raised.
- R7: When a COD character is accepted with a non-zero count remaining after it, isb_o[2] and isb_o[0] both become 1 and exc_o is raised. A COD on the last counted byte reports no incorrect length.
- R8: status_o[13] and status_o[14] are always 0. All status bits other than 0, 5 and 7 stay 0.
- R9: A stat_rd_i or start_i pulse clears status_o and isb_o in the next cycle. An error on a character accepted in the same cycle as stat_rd_i is kept.
- R10: exc_o is never high for two cycles in a row. cnt_o drops by one for each accepted character.
- R11: start_i loads cnt_o from cnt_init_i and activates the operation when the value is non-zero. Characters offered while the operation is inactive, or in the cycle of start_i, change no output. A last byte with chain_i high ends the operation without an exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a receive operation, load the count, clear status |
| cnt_init_i | input | CW | Byte count loaded by start_i |
| chain_i | input | 1 | Chaining bit of the current operation |
| zero_inh_i | input | 1 | Keep bad-parity characters instead of zeroing them |
| stat_rd_i | input | 1 | Status read, clears accumulated status |
| chr_vld_i | input | 1 | A received character is offered |
| chr_data_i | input | DW | Received character |
| chr_perr_i | input | 1 | Parity error on the character |
| chr_stoperr_i | input | 1 | Missing stop bit on the character |
| chr_cod_i | input | 1 | Character is the end-of-message code |
| dma_busy_i | input | 1 | Previous byte not yet written to memory |
| st_wr_o | output | 1 | Store strobe |
| st_data_o | output | DW | Byte to store |
| cnt_o | output | CW | Remaining byte count |
| status_o | output | 16 | Accumulated status word |
| isb_o | output | 8 | Interrupt status bits |
| exc_o | output | 1 | One-cycle exception request |

## Verification
Two events can land in the same cycle: a status read clearing the word, and an accepted character setting a new error bit. The bench provokes this by asserting stat_rd_i together with a stop-bit-error character after a parity error has been recorded. It expects the old parity bit gone and the new stop bit present. It also makes a COD coincide with the last counted byte, and overrun coincide with a parity error. In both cases the expected deferred exception and the combined bits are judged by a behavioural model that is compared on every clock.

// File: rtl/rxacc_pkg.sv
package rxacc_pkg;
  localparam int ST_W  = 16;
  localparam int ISB_W = 8;

  // status word bit positions
  localparam int ST_OVR  = 0;
  localparam int ST_PAR  = 5;
  localparam int ST_STOP = 7;
  localparam logic [ST_W-1:0] ST_KEEP_MASK = 16'h00A1;

  // interrupt status bit positions
  localparam int ISB_DDS = 0;
  localparam int ISB_LEN = 2;

  typedef struct packed {
    logic perr;
    logic serr;
    logic cod;
  } chr_flags_t;
endpackage

// File: rtl/rxacc_store.sv
module rxacc_store #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept_i,
  input  logic          zero_inh_i,
  input  logic          perr_i,
  input  logic [DW-1:0] data_i,
  output logic          wr_o,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] subst;

  // bad parity becomes all zeros unless inhibited
  assign subst = (perr_i && !zero_inh_i) ? '0 : data_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_o   <= 1'b0;
      data_o <= '0;
    end else begin
      wr_o <= accept_i;
      if (accept_i) data_o <= subst;
    end
  end
endmodule

// File: rtl/rxacc_count.sv
module rxacc_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [CW-1:0] init_i,
  input  logic          accept_i,
  input  logic          end_i,
  output logic [CW-1:0] cnt_o,
  output logic          active_o,
  output logic          last_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  assign last_o = (cnt_o == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o    <= '0;
      active_o <= 1'b0;
    end else if (start_i) begin
      cnt_o    <= init_i;
      active_o <= |init_i;
    end else if (accept_i) begin
      cnt_o <= cnt_o - ONE;
      if (end_i) active_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rxacc_flags.sv
module rxacc_flags
  import rxacc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             rd_i,
  input  logic             accept_i,
  input  chr_flags_t       chr_i,
  input  logic             busy_i,
  input  logic             last_i,
  input  logic             chain_i,
  output logic [ST_W-1:0]  status_o,
  output logic [ISB_W-1:0] isb_o,
  output logic             exc_o
);
  logic [ST_W-1:0]  st_d;
  logic [ISB_W-1:0] isb_d;
  logic             pend_q, pend_d, exc_d;
  logic             pend_now, len_err, msg_end;

  always_comb begin
    pend_now = pend_q | chr_i.perr | busy_i;
    len_err  = (chr_i.cod & ~last_i) | (last_i & ~chr_i.cod & ~chain_i);
    msg_end  = chr_i.cod | (last_i & ~chain_i);
    st_d     = (start_i | rd_i) ? '0 : status_o;
    isb_d    = (start_i | rd_i) ? '0 : isb_o;
    pend_d   = pend_q;
    exc_d    = 1'b0;
    if (start_i) begin
      pend_d = 1'b0;
    end else if (accept_i) begin
      st_d[ST_OVR]  = st_d[ST_OVR]  | busy_i;
      st_d[ST_PAR]  = st_d[ST_PAR]  | chr_i.perr;
      st_d[ST_STOP] = st_d[ST_STOP] | chr_i.serr;
      if (len_err) begin
        isb_d[ISB_LEN] = 1'b1;
        isb_d[ISB_DDS] = chr_i.cod;
      end
      exc_d  = chr_i.serr | len_err | (msg_end & pend_now);
      pend_d = exc_d ? 1'b0 : pend_now;
    end
    st_d = st_d & ST_KEEP_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      isb_o    <= '0;
      pend_q   <= 1'b0;
      exc_o    <= 1'b0;
    end else begin
      status_o <= st_d;
      isb_o    <= isb_d;
      pend_q   <= pend_d;
      exc_o    <= exc_d;
    end
  end
endmodule

// File: rtl/rx_char_status_acc.sv
module rx_char_status_acc
  import rxacc_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CW-1:0]    cnt_init_i,
  input  logic             chain_i,
  input  logic             zero_inh_i,
  input  logic             stat_rd_i,
  input  logic             chr_vld_i,
  input  logic [DW-1:0]    chr_data_i,
  input  logic             chr_perr_i,
  input  logic             chr_stoperr_i,
  input  logic             chr_cod_i,
  input  logic             dma_busy_i,
  output logic             st_wr_o,
  output logic [DW-1:0]    st_data_o,
  output logic [CW-1:0]    cnt_o,
  output logic [ST_W-1:0]  status_o,
  output logic [ISB_W-1:0] isb_o,
  output logic             exc_o
);
  logic       active, last, accept, op_end;
  chr_flags_t chr;

  assign chr.perr = chr_perr_i;
  assign chr.serr = chr_stoperr_i;
  assign chr.cod  = chr_cod_i;

  assign accept = chr_vld_i & active & ~start_i;
  assign op_end = chr_cod_i | chr_stoperr_i | last;

  rxacc_store #(.DW(DW)) u_store (
    .clk        (clk),
    .rst        (rst),
    .accept_i   (accept),
    .zero_inh_i (zero_inh_i),
    .perr_i     (chr_perr_i),
    .data_i     (chr_data_i),
    .wr_o       (st_wr_o),
    .data_o     (st_data_o)
  );

  rxacc_count #(.CW(CW)) u_count (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .init_i   (cnt_init_i),
    .accept_i (accept),
    .end_i    (op_end),
    .cnt_o    (cnt_o),
    .active_o (active),
    .last_o   (last)
  );

  rxacc_flags u_flags (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .rd_i     (stat_rd_i),
    .accept_i (accept),
    .chr_i    (chr),
    .busy_i   (dma_busy_i),
    .last_i   (last),
    .chain_i  (chain_i),
    .status_o (status_o),
    .isb_o    (isb_o),
    .exc_o    (exc_o)
  );
endmodule

// File: rtl/rxacc_chk.sv
module rxacc_chk #(
  parameter int DW = 8,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          zero_inh_i,
  input logic          chr_vld_i,
  input logic          chr_perr_i,
  input logic          chr_stoperr_i,
  input logic          st_wr_o,
  input logic [DW-1:0] st_data_o,
  input logic [CW-1:0] cnt_o,
  input logic [15:0]   status_o,
  input logic          exc_o
);
  p_zero_sub_r2: assert property (@(posedge clk) disable iff (rst)
    (st_wr_o && $past(chr_vld_i && chr_perr_i && !zero_inh_i)) |-> (st_data_o == '0));

  p_par_bit_r3: assert property (@(posedge clk) disable iff (rst)
    (st_wr_o && $past(chr_vld_i && chr_perr_i)) |-> status_o[5]);

  p_stop_exc_r4: assert property (@(posedge clk) disable iff (rst)
    (st_wr_o && $past(chr_vld_i && chr_stoperr_i)) |-> (exc_o && status_o[7]));

  p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (rst)
    status_o[14:13] == 2'b00);

  p_exc_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    exc_o |=> !exc_o);

  p_cnt_dec_r10: assert property (@(posedge clk) disable iff (rst)
    st_wr_o |-> (cnt_o == $past(cnt_o) - CW'(1)));

  p_ignore_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(start_i) && !st_wr_o) |-> $stable(cnt_o));
endmodule

bind rx_char_status_acc rxacc_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .start_i       (start_i),
  .zero_inh_i    (zero_inh_i),
  .chr_vld_i     (chr_vld_i),
  .chr_perr_i    (chr_perr_i),
  .chr_stoperr_i (chr_stoperr_i),
  .st_wr_o       (st_wr_o),
  .st_data_o     (st_data_o),
  .cnt_o         (cnt_o),
  .status_o      (status_o),
  .exc_o         (exc_o)
);

// File: tb/rx_char_status_acc_tb.sv
module rx_char_status_acc_tb;
  localparam int TCLK = 10;
  localparam int DW = 8;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0, chain_i = 1'b0, zero_inh_i = 1'b0, stat_rd_i = 1'b0;
  logic [CW-1:0] cnt_init_i = '0;
  logic          chr_vld_i = 1'b0, chr_perr_i = 1'b0, chr_stoperr_i = 1'b0, chr_cod_i = 1'b0;
  logic          dma_busy_i = 1'b0;
  logic [DW-1:0] chr_data_i = '0;
  logic          st_wr_o, exc_o;
  logic [DW-1:0] st_data_o;
  logic [CW-1:0] cnt_o;
  logic [15:0]   status_o;
  logic [7:0]    isb_o;

  int total = 0, bad = 0;

  always #(TCLK/2) clk = ~clk;

  rx_char_status_acc #(.DW(DW), .CW(CW)) u_dut (.*);

  // behavioural reference model
  int   m_cnt = 0, m_data = 0, m_stat = 0, m_isb = 0;
  bit   m_active = 0, m_pend = 0, m_wr = 0, m_exc = 0;

  always @(posedge clk) begin
    bit acc, last, inclen, ends, pnow;
    if (rst) begin
      m_cnt = 0; m_data = 0; m_stat = 0; m_isb = 0;
      m_active = 0; m_pend = 0; m_wr = 0; m_exc = 0;
    end else begin
      acc  = chr_vld_i && m_active && !start_i;
      last = (m_cnt == 1);
      if (start_i || stat_rd_i) begin m_stat = 0; m_isb = 0; end
      m_wr  = acc;
      m_exc = 0;
      if (start_i) begin
        m_cnt = int'(cnt_init_i); m_active = (cnt_init_i != 0); m_pend = 0;
      end else if (acc) begin
        m_data = (chr_perr_i && !zero_inh_i) ? 0 : int'(chr_data_i);
        if (dma_busy_i)    m_stat = m_stat | 'h01;
        if (chr_perr_i)    m_stat = m_stat | 'h20;
        if (chr_stoperr_i) m_stat = m_stat | 'h80;
        pnow   = m_pend || chr_perr_i || dma_busy_i;
        inclen = (chr_cod_i && !last) || (last && !chr_cod_i && !chain_i);
        ends   = chr_cod_i || (last && !chain_i);
        if (inclen) m_isb = (m_isb & ~1) | 4 | (chr_cod_i ? 1 : 0);
        m_exc  = chr_stoperr_i || inclen || (ends && pnow);
        m_pend = m_exc ? 0 : pnow;
        m_cnt  = m_cnt - 1;
        if (chr_stoperr_i || chr_cod_i || last) m_active = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    chk("R1 store strobe vs model", 32'(st_wr_o), 32'(m_wr));
    chk("R2 stored byte vs model", 32'(st_data_o), m_data);
    chk("R5 status word vs model", 32'(status_o), m_stat);
    chk("R6 interrupt status vs model", 32'(isb_o), m_isb);
    chk("R10 exception vs model", 32'(exc_o), 32'(m_exc));
    chk("R10 byte count vs model", 32'(cnt_o), m_cnt);
  endtask

  task automatic start(input int n, input bit ch, input bit zi);
    start_i = 1; cnt_init_i = CW'(n); chain_i = ch; zero_inh_i = zi;
    tick();
    start_i = 0;
  endtask

  task automatic send(input int d, input bit pe, input bit se, input bit cod, input bit busy);
    chr_vld_i = 1; chr_data_i = DW'(d); chr_perr_i = pe; chr_stoperr_i = se;
    chr_cod_i = cod; dma_busy_i = busy;
    tick();
    chr_vld_i = 0; chr_perr_i = 0; chr_stoperr_i = 0; chr_cod_i = 0; dma_busy_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    chk("R11 reset count", 32'(cnt_o), 0);
    chk("R9 reset status", 32'(status_o), 0);
    chk("R10 reset exception", 32'(exc_o), 0);

    // count runs out without COD
    start(4, 0, 0);
    chk("R11 count loaded", 32'(cnt_o), 4);
    for (int i = 0; i < 3; i++) begin
      send('hA1 + i, 0, 0, 0, 0);
      chk("R1 byte stored", 32'(st_data_o), 'hA1 + i);
      chk("R6 no early exception", 32'(exc_o), 0);
    end
    send('hB0, 0, 0, 0, 0);
    chk("R6 length bits", 32'(isb_o), 'h04);
    chk("R6 exception", 32'(exc_o), 1);
    chk("R10 count zero", 32'(cnt_o), 0);
    tick();
    chk("R10 single pulse", 32'(exc_o), 0);
    send('h33, 0, 0, 0, 0);
    chk("R11 inactive ignored", 32'(st_wr_o), 0);
    stat_rd_i = 1; tick(); stat_rd_i = 0;
    chk("R9 read clears isb", 32'(isb_o), 0);

    // parity deferred, early COD
    start(5, 0, 0);
    send('h55, 1, 0, 0, 0);
    chk("R2 zeroed byte", 32'(st_data_o), 0);
    chk("R3 parity bit", 32'(status_o[5]), 1);
    chk("R3 deferred", 32'(exc_o), 0);
    send('h66, 0, 0, 0, 0);
    send('h77, 0, 0, 1, 0);
    chk("R7 early COD bits", 32'(isb_o), 'h05);
    chk("R7 exception", 32'(exc_o), 1);

    // raw keep, then stop error
    start(3, 0, 1);
    chk("R9 start clears", 32'(status_o), 0);
    send('h5A, 1, 0, 0, 0);
    chk("R2 raw byte kept", 32'(st_data_o), 'h5A);
    send('h11, 0, 1, 0, 0);
    chk("R4 immediate exception", 32'(exc_o), 1);
    chk("R4 stop and parity bits", 32'(status_o), 'hA0);
    send('h22, 0, 0, 0, 0);
    chk("R4 operation ended", 32'(cnt_o), 1);
    chk("R11 ignored after end", 32'(st_wr_o), 0);

    // overrun with parity, COD on last byte
    start(2, 0, 0);
    send('h44, 1, 0, 0, 1);
    chk("R5 overrun with parity", 32'(status_o), 'h21);
    send('h45, 0, 0, 1, 0);
    chk("R7 COD on last byte no length", 32'(isb_o), 0);
    chk("R5 deferred exception", 32'(exc_o), 1);
    chk("R8 reserved bits", 32'(status_o[14:13]), 0);

    // read coinciding with a new error
    start(3, 0, 0);
    send('h10, 1, 0, 0, 0);
    stat_rd_i = 1;
    send('h12, 0, 1, 0, 0);
    stat_rd_i = 0;
    chk("R9 read and set same cycle", 32'(status_o), 'h80);

    // start and character together
    cnt_init_i = CW'(2); start_i = 1; chain_i = 0;
    send('h99, 0, 0, 0, 0);
    start_i = 0;
    chk("R11 start wins", 32'(st_wr_o), 0);
    chk("R11 count from start", 32'(cnt_o), 2);

    // chained last byte ends quietly
    start(1, 1, 0);
    send('h01, 0, 0, 0, 0);
    chk("R11 chained end no exception", 32'(exc_o), 0);
    chk("R11 chained end no isb", 32'(isb_o), 0);
    tick();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule